// File: doc/BRIEF.md
# Four-Channel Shadowed Pulse-Width Modulator

This block drives four pulse-width-modulated outputs from a single externally supplied tick strobe, nominally one pulse per microsecond. Each channel owns a period value, an active-time value and a small control word. The control word picks a power-of-two slowdown of the tick and can flip the output sense. Software programs the channels through a plain synchronous register bus. Writes complete in the cycle they are presented, and reads are combinational from the address.

Settings are double-buffered. The bus writes only the visible copies. A channel copies all of them into its working state at one instant: the end of the period that is running when the period value is written. Software can therefore rewrite the active time and the control word in any order, then write the period to release them together, and the output never shows a mixed waveform. A period value of zero stops the channel gently: the current period is finished first, and the output then rests low.

Top module: `pwm_shadow_ctrl`

## Requirements
- R1: After reset every register reads 0 and every output is low.
- R2: Channel c (0..3) has its period at byte address 0x400+4c, its active time at 0x420+4c and its control word at 0x440+4c. Reads return the value last written, not the working copy. Period and active time are 16 bits wide. The control word keeps only bits [1:0] and bit 5, and its other bits read 0. An unmapped address reads 0.
- R3: A running channel with period P and active time D steps a count from 0 to P-1. Its output is active while the count is below D. A D of 0 is never active, and a D of P or more is always active.
- R4: Control bits [1:0] = k make each count step last 2^k tick strobes, so one period spans P·2^k strobes.
- R5: Control bit 5 = 1 inverts the output while the channel runs.
- R6: Writes to the active time and the control word leave the waveform unchanged until the period register is written. The new period, active time and control word then take effect together at the end of the running period.
- R7: Writing a period of 0 lets the current period finish, after which the output stays low whatever the polarity bit says.
- R8: A stopped channel that receives a nonzero period write loads its settings on the next clock edge and starts at count 0 at once.
- R9: Channels are independent, so programming one channel does not disturb another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Timebase strobe, one clock wide |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 12 | Byte address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i |
| pwm_o | output | 4 | Channel outputs, bit c for channel c |

## Verification
The waveform is measured in tick strobes between two rising active edges. Several period, active-time and divider combinations are used, and each one separates correct count wrapping from an off-by-one or a wrong divider. Inverted polarity, a zero active time and an active time above the period cover the edges of the comparison. A shadowed active-time change with no period write must leave the measured waveform untouched, and the following period write must change the active time and divider together. A stop request issued just after a period begins must still give almost a full active phase before the output rests low, which tells a graceful stop from an immediate one.

// File: rtl/pwm_shadow_pkg.sv
`timescale 1ns/1ps
package pwm_shadow_pkg;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_PER  = 2'd1,
      SEL_DUTY = 2'd2,
      SEL_CTRL = 2'd3
   } reg_sel_e;

   // Map an address onto the register group of one channel.
   function automatic reg_sel_e sel_of(input logic [31:0] addr,
                                       input int per_b, input int duty_b,
                                       input int ctrl_b, input int stride,
                                       input int ch);
      reg_sel_e s;
      s = SEL_NONE;
      if (addr == 32'(per_b + stride * ch))  s = SEL_PER;
      if (addr == 32'(duty_b + stride * ch)) s = SEL_DUTY;
      if (addr == 32'(ctrl_b + stride * ch)) s = SEL_CTRL;
      return s;
   endfunction

endpackage

// File: rtl/pwm_shadow_regs.sv
`timescale 1ns/1ps
module pwm_shadow_regs #(
   parameter int CNT_W = 16,
   parameter int DIV_W = 2,
   parameter int INV_BIT = 5
) (
   input  logic                          clk_i,
   input  logic                          rst_ni,
   input  logic                          wr_en_i,
   input  pwm_shadow_pkg::reg_sel_e      sel_i,
   input  logic [CNT_W-1:0]              wdata_i,
   input  logic                          commit_i,
   output logic [CNT_W-1:0]              per_o,
   output logic [CNT_W-1:0]              duty_o,
   output logic [DIV_W-1:0]              div_o,
   output logic                          inv_o,
   output logic                          pend_o
);
   import pwm_shadow_pkg::*;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         per_o  <= '0;
         duty_o <= '0;
         div_o  <= '0;
         inv_o  <= 1'b0;
         pend_o <= 1'b0;
      end else begin
         // a period write arms the transfer; it wins over a same-cycle commit
         if (wr_en_i && sel_i == SEL_PER) begin
            per_o  <= wdata_i;
            pend_o <= 1'b1;
         end else if (commit_i) begin
            pend_o <= 1'b0;
         end
         if (wr_en_i && sel_i == SEL_DUTY) duty_o <= wdata_i;
         if (wr_en_i && sel_i == SEL_CTRL) begin
            div_o <= wdata_i[DIV_W-1:0];
            inv_o <= wdata_i[INV_BIT];
         end
      end
   end

endmodule

// File: rtl/pwm_shadow_core.sv
`timescale 1ns/1ps
module pwm_shadow_core #(
   parameter int CNT_W = 16,
   parameter int DIV_W = 2,
   parameter bit OUT_REG = 1'b0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             tick_i,
   input  logic             pend_i,
   input  logic [CNT_W-1:0] sh_per_i,
   input  logic [CNT_W-1:0] sh_duty_i,
   input  logic [DIV_W-1:0] sh_div_i,
   input  logic             sh_inv_i,
   output logic             commit_o,
   output logic             run_o,
   output logic             last_o,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] per_o,
   output logic [CNT_W-1:0] duty_o,
   output logic             pwm_o
);
   localparam int PS_W = (1 << DIV_W) - 1;

   logic [PS_W-1:0]  ps_q;
   logic [PS_W-1:0]  ps_lim;
   logic [DIV_W-1:0] div_q;
   logic             inv_q;
   logic             ptick;
   logic             level;

   assign ps_lim   = ~({PS_W{1'b1}} << div_q);
   assign ptick    = run_o & tick_i & (ps_q == ps_lim);
   assign last_o   = ptick & (cnt_o == per_o - CNT_W'(1));
   assign commit_o = pend_i & (~run_o | last_o);
   assign level    = run_o & ((cnt_o < duty_o) ^ inv_q);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         run_o  <= 1'b0;
         cnt_o  <= '0;
         ps_q   <= '0;
         per_o  <= '0;
         duty_o <= '0;
         div_q  <= '0;
         inv_q  <= 1'b0;
      end else if (commit_o) begin
         per_o  <= sh_per_i;
         duty_o <= sh_duty_i;
         div_q  <= sh_div_i;
         inv_q  <= sh_inv_i;
         run_o  <= (sh_per_i != '0);
         cnt_o  <= '0;
         ps_q   <= '0;
      end else if (run_o && tick_i) begin
         ps_q <= (ps_q == ps_lim) ? '0 : ps_q + PS_W'(1);
         if (ptick) cnt_o <= last_o ? '0 : cnt_o + CNT_W'(1);
      end
   end

   generate
      if (OUT_REG) begin : g_out_ff
         always_ff @(posedge clk_i) begin
            if (!rst_ni) pwm_o <= 1'b0;
            else         pwm_o <= level;
         end
      end else begin : g_out_comb
         assign pwm_o = level;
      end
   endgenerate

endmodule

// File: rtl/pwm_shadow_ctrl.sv
`timescale 1ns/1ps
module pwm_shadow_ctrl #(
   parameter int NUM_CH    = 4,
   parameter int CNT_W     = 16,
   parameter int DIV_W     = 2,
   parameter int INV_BIT   = 5,
   parameter int ADDR_W    = 12,
   parameter int PER_BASE  = 'h400,
   parameter int DUTY_BASE = 'h420,
   parameter int CTRL_BASE = 'h440,
   parameter int STRIDE    = 4,
   parameter bit OUT_REG   = 1'b0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [CNT_W-1:0]  wdata_i,
   output logic [CNT_W-1:0]  rdata_o,
   output logic [NUM_CH-1:0] pwm_o
);
   import pwm_shadow_pkg::*;

   localparam int SPAN = NUM_CH * STRIDE;

   initial begin
      if (INV_BIT < DIV_W || INV_BIT >= CNT_W)
         $error("polarity bit overlaps divider or exceeds data width");
      if (SPAN > DUTY_BASE - PER_BASE || SPAN > CTRL_BASE - DUTY_BASE)
         $error("register groups overlap");
      if (CTRL_BASE + SPAN > (1 << ADDR_W))
         $error("address width too small");
   end

   reg_sel_e                      sel_w   [NUM_CH];
   logic [NUM_CH-1:0][CNT_W-1:0]  sh_per_w, sh_duty_w;
   logic [NUM_CH-1:0][DIV_W-1:0]  sh_div_w;
   logic [NUM_CH-1:0]             sh_inv_w, pend_w, commit_w, run_w, last_w;
   logic [NUM_CH-1:0][CNT_W-1:0]  cnt_w, act_per_w, act_duty_w;

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         assign sel_w[c] = sel_of(32'(addr_i), PER_BASE, DUTY_BASE,
                                  CTRL_BASE, STRIDE, c);

         pwm_shadow_regs #(.CNT_W(CNT_W), .DIV_W(DIV_W), .INV_BIT(INV_BIT)) regs_i (
            .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i),
            .sel_i(sel_w[c]), .wdata_i(wdata_i), .commit_i(commit_w[c]),
            .per_o(sh_per_w[c]), .duty_o(sh_duty_w[c]), .div_o(sh_div_w[c]),
            .inv_o(sh_inv_w[c]), .pend_o(pend_w[c]));

         pwm_shadow_core #(.CNT_W(CNT_W), .DIV_W(DIV_W), .OUT_REG(OUT_REG)) core_i (
            .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .pend_i(pend_w[c]),
            .sh_per_i(sh_per_w[c]), .sh_duty_i(sh_duty_w[c]),
            .sh_div_i(sh_div_w[c]), .sh_inv_i(sh_inv_w[c]),
            .commit_o(commit_w[c]), .run_o(run_w[c]), .last_o(last_w[c]),
            .cnt_o(cnt_w[c]), .per_o(act_per_w[c]), .duty_o(act_duty_w[c]),
            .pwm_o(pwm_o[c]));
      end
   endgenerate

   // read path returns the visible copies
   always_comb begin
      rdata_o = '0;
      for (int c = 0; c < NUM_CH; c++) begin
         case (sel_w[c])
            SEL_PER:  rdata_o = rdata_o | sh_per_w[c];
            SEL_DUTY: rdata_o = rdata_o | sh_duty_w[c];
            SEL_CTRL: begin
               rdata_o[DIV_W-1:0] = rdata_o[DIV_W-1:0] | sh_div_w[c];
               rdata_o[INV_BIT]   = rdata_o[INV_BIT] | sh_inv_w[c];
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/pwm_shadow_chk.sv
`timescale 1ns/1ps
module pwm_shadow_chk #(
   parameter int NUM_CH = 4,
   parameter int CNT_W  = 16
) (
   input logic                          clk_i,
   input logic                          rst_ni,
   input logic [NUM_CH-1:0]             pwm_o,
   input logic [NUM_CH-1:0]             run_w,
   input logic [NUM_CH-1:0]             commit_w,
   input logic [NUM_CH-1:0]             pend_w,
   input logic [NUM_CH-1:0]             last_w,
   input logic [NUM_CH-1:0][CNT_W-1:0]  cnt_w,
   input logic [NUM_CH-1:0][CNT_W-1:0]  act_per_w,
   input logic [NUM_CH-1:0][CNT_W-1:0]  act_duty_w
);
   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_c
         AST_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!run_w[c] && !$past(run_w[c])) |-> !pwm_o[c]);  // R7
         AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
            run_w[c] |-> (cnt_w[c] < act_per_w[c]));  // R3
         AST_SETTINGS_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !commit_w[c] |=> ($stable(act_per_w[c]) && $stable(act_duty_w[c])));  // R6
         AST_RUN_FOLLOWS_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
            commit_w[c] |=> (run_w[c] == (act_per_w[c] != '0)));  // R8
         AST_PERIOD_WRAPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (last_w[c] && !pend_w[c]) |=> (run_w[c] && cnt_w[c] == '0));  // R3
      end
   endgenerate
endmodule

bind pwm_shadow_ctrl pwm_shadow_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) chk_i (
   .clk_i(clk_i), .rst_ni(rst_ni), .pwm_o(pwm_o), .run_w(run_w),
   .commit_w(commit_w), .pend_w(pend_w), .last_w(last_w), .cnt_w(cnt_w),
   .act_per_w(act_per_w), .act_duty_w(act_duty_w));

// File: tb/pwm_shadow_ctrl_tb_top.sv
`timescale 1ns/1ps
module pwm_shadow_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        we = 1'b0;
   logic [11:0] addr = '0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic [3:0]  pwm;
   int          n_run = 0;
   int          n_fail = 0;

   always #2.5 clk = ~clk;

   pwm_shadow_ctrl dut_i (.clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(we),
      .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .pwm_o(pwm));

   initial forever begin
      @(negedge clk);
      tick = ~tick;
   end

   function automatic logic [11:0] a_per(int c);  return 12'(16'h400 + 4*c); endfunction
   function automatic logic [11:0] a_duty(int c); return 12'(16'h420 + 4*c); endfunction
   function automatic logic [11:0] a_ctrl(int c); return 12'(16'h440 + 4*c); endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [15:0] d);
      @(negedge clk);
      addr = a; wdata = d; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [15:0] d);
      @(negedge clk);
      addr = a;
      #1 d = rdata;
   endtask

   // output value right after the next tick strobe has taken effect
   task automatic samp(input int c, output logic s);
      do @(posedge clk); while (!tick);
      #1 s = pwm[c];
   endtask

   task automatic wait_ticks(input int n);
      logic s;
      for (int i = 0; i < n; i++) samp(0, s);
   endtask

   // strobes active and strobes per period, between two rising active edges
   task automatic measure(input int c, input bit inv, output int hi, output int tot);
      logic s, prev;
      bit   found, done;
      prev = 1'b1; found = 0; done = 0; hi = 0; tot = 0;
      for (int i = 0; i < 4000 && !done; i++) begin
         samp(c, s);
         s = s ^ inv;
         if (!found) begin
            if (s && !prev) begin found = 1; hi = 1; tot = 1; end
         end else if (s && !prev) begin
            done = 1;
         end else begin
            tot++;
            hi += int'(s);
         end
         prev = s;
      end
      if (!done) begin hi = 0; tot = 0; end
   endtask

   task automatic expect_wave(input int c, input bit inv, input int ehi, input int etot,
                              input string req);
      int hi, tot;
      measure(c, inv, hi, tot);
      chk(hi == ehi, req, hi, ehi);
      chk(tot == etot, req, tot, etot);
   endtask

   task automatic expect_flat(input int c, input logic lvl, input int n, input string req);
      logic s;
      int   bad;
      bad = 0;
      for (int i = 0; i < n; i++) begin samp(c, s); if (s !== lvl) bad++; end
      chk(bad == 0, req, bad, 0);
   endtask

   task automatic t_reset;
      logic [15:0] d;
      chk(pwm == 4'b0, "R1 outputs", int'(pwm), 0);
      for (int c = 0; c < 4; c++) begin
         rd(a_per(c), d);  chk(d == 0, "R1 period", int'(d), 0);
         rd(a_duty(c), d); chk(d == 0, "R1 duty", int'(d), 0);
         rd(a_ctrl(c), d); chk(d == 0, "R1 ctrl", int'(d), 0);
      end
   endtask

   task automatic t_readback;
      logic [15:0] d;
      wr(a_ctrl(3), 16'hFFFF);
      wr(a_duty(3), 16'hABCD);
      wr(a_per(3), 16'h0007);
      rd(a_ctrl(3), d); chk(d == 16'h0023, "R2 ctrl", int'(d), 'h23);
      rd(a_duty(3), d); chk(d == 16'hABCD, "R2 duty", int'(d), 'hABCD);
      rd(a_per(3), d);  chk(d == 16'h0007, "R2 period", int'(d), 7);
      rd(12'h460, d);   chk(d == 0, "R2 unmapped", int'(d), 0);
      rd(a_per(2), d);  chk(d == 0, "R9 other channel", int'(d), 0);
   endtask

   task automatic t_basic;
      logic s;
      wr(a_ctrl(0), 16'h0000);
      wr(a_duty(0), 16'd2);
      wr(a_per(0), 16'd5);
      @(posedge clk); #1 s = pwm[0];
      chk(s == 1'b1, "R8 immediate start", int'(s), 1);
      expect_wave(0, 0, 2, 5, "R3 basic 2/5");
   endtask

   task automatic t_prescale;
      wr(a_ctrl(1), 16'h0002);
      wr(a_duty(1), 16'd1);
      wr(a_per(1), 16'd4);
      expect_wave(1, 0, 4, 16, "R4 divide by 4");
   endtask

   task automatic t_polarity;
      wr(a_ctrl(2), 16'h0020);
      wr(a_duty(2), 16'd2);
      wr(a_per(2), 16'd6);
      expect_wave(2, 1, 2, 6, "R5 inverted");
   endtask

   task automatic t_duty_edges;
      wr(a_ctrl(3), 16'h0000);
      wr(a_duty(3), 16'd0);
      wr(a_per(3), 16'd3);
      wait_ticks(80);
      expect_flat(3, 1'b0, 20, "R3 duty zero");
      wr(a_duty(3), 16'd7);
      wr(a_per(3), 16'd3);
      wait_ticks(20);
      expect_flat(3, 1'b1, 20, "R3 duty above period");
   endtask

   task automatic t_shadow;
      logic [15:0] d;
      wr(a_duty(0), 16'd4);
      wr(a_ctrl(0), 16'h0001);
      wait_ticks(12);
      expect_wave(0, 0, 2, 5, "R6 held without period write");
      rd(a_duty(0), d); chk(d == 16'd4, "R2 reads written duty", int'(d), 4);
      wr(a_per(0), 16'd5);
      expect_wave(0, 0, 8, 10, "R6 joint update");
      expect_wave(1, 0, 4, 16, "R9 channel 1 undisturbed");
   endtask

   task automatic t_disable;
      logic s;
      int   hi, tail;
      wr(a_ctrl(0), 16'h0000);
      wr(a_duty(0), 16'd100);
      wr(a_per(0), 16'd200);
      expect_wave(0, 0, 100, 200, "R3 long period");
      wr(a_per(0), 16'd0);
      hi = 0; tail = 0;
      for (int i = 0; i < 400; i++) begin
         samp(0, s);
         hi += int'(s);
         if (i >= 300 && s) tail++;
      end
      chk(hi >= 95 && hi <= 100, "R7 period completes", hi, 99);
      chk(tail == 0, "R7 rests low", tail, 0);
      wr(a_per(2), 16'd0);
      wait_ticks(30);
      expect_flat(2, 1'b0, 20, "R7 low despite inversion");
   endtask

   task automatic t_restart;
      wr(a_duty(0), 16'd3);
      wr(a_per(0), 16'd5);
      expect_wave(0, 0, 3, 5, "R8 restart from idle");
   endtask

   initial begin
      #(5.0 * 150000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_readback();
      t_basic();
      t_prescale();
      t_polarity();
      t_duty_edges();
      t_shadow();
      t_disable();
      t_restart();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule